// File: doc/BRIEF.md
# Partitioned Wide Binary Up-Counter

This block is a wide binary up-counter built from a chain of partitions. The lowest partition is narrow and advances on every enabled clock. Each higher partition advances by one only on a cycle where every partition below it is about to roll over. Any one cycle therefore has a carry path no longer than the width of a single partition plus a short AND of precomputed "full" flags. The reachable clock rate then depends on the partition width and not on the total count width.

The counter is controlled by a single count-enable. When the enable is low, every partition holds its value. The output is the partitions joined end to end, with the lowest partition in the least significant bits. Counted over the same number of enabled cycles, that value is identical to what a single flat counter of the full width would show, including the wrap to zero. A terminal-count flag marks the all-ones value. The upper partitions change at most once every 2^LOW_W clocks, so they may be treated as multicycle paths or run from a gated clock. Here that gating is modelled by the synchronous step enable.

Top module: `prescaled_counter`

## Requirements
- R1: On a cycle with `rst` high, the next clock edge sets `count_value` to zero and `terminal_count` low, whatever the value of `count_en`.
- R2: When `count_en` is high and `rst` is low, `count_value` after the edge equals its previous value plus one, modulo 2^W, where W = LOW_W + UPPER_W*NUM_UPPER.
- R3: When `count_en` is low and `rst` is low, `count_value` keeps its value across the edge.
- R4: Bits [LOW_W-1:0] hold the low partition, and it advances on every enabled cycle.
- R5: An upper partition changes only on an enabled cycle in which all partitions below it are all ones. On such a cycle it increments by exactly one.
- R6: From the all-ones value, one enabled cycle wraps `count_value` to zero.
- R7: `terminal_count` is high exactly when `count_value` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| count_en | input | 1 | Count enable; low freezes all partitions |
| count_value | output | W | Joined partition values, low partition in the LSBs |
| terminal_count | output | 1 | High while the count is all ones |

## Verification
The assertions assume that `count_en` and `rst` are known (not X) at every rising edge after reset is released. They also assume that reset is held for at least one edge before counting is checked. The stimulus meets both conditions: it changes the inputs only on falling edges, and it starts with a reset held for several cycles. Enable is drawn from `$urandom` with a bias toward high, so that several full wraps of the low partition occur and the upper partitions roll over as well. Enable-low stretches and a reset issued while the counter is enabled are mixed in.

// File: rtl/prescaled_counter_pkg.sv
package prescaled_counter_pkg;

  // Bit offset of partition idx: partition 0 is LOW_W wide, the rest UPPER_W.
  function automatic int part_lsb(input int idx, input int low_w, input int upper_w);
    if (idx == 0) return 0;
    return low_w + (idx - 1) * upper_w;
  endfunction

  function automatic int part_width(input int idx, input int low_w, input int upper_w);
    return (idx == 0) ? low_w : upper_w;
  endfunction

endpackage

// File: rtl/pc_segment.sv
module pc_segment #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [SW-1:0] val,
  output logic          full
);
  localparam logic [SW-1:0] ONES    = '1;
  localparam logic [SW-1:0] PRE_MAX = ONES - 1'b1;

  // full is registered so the enable chain sees a flop output, not a compare.
  always_ff @(posedge clk) begin
    if (rst) begin
      val  <= '0;
      full <= 1'b0;
    end else if (step) begin
      val  <= val + 1'b1;
      full <= (val == PRE_MAX);
    end
  end
endmodule

// File: rtl/pc_enable_chain.sv
module pc_enable_chain #(
  parameter int NSEG = 3
) (
  input  logic            en,
  input  logic [NSEG-1:0] full,
  output logic [NSEG-1:0] step
);
  assign step[0] = en;
  for (genvar i = 1; i < NSEG; i++) begin : g_link
    assign step[i] = step[i-1] & full[i-1];
  end
endmodule

// File: rtl/prescaled_counter.sv
module prescaled_counter
  import prescaled_counter_pkg::*;
#(
  parameter int LOW_W     = 4,
  parameter int UPPER_W   = 3,
  parameter int NUM_UPPER = 2,
  localparam int NSEG     = NUM_UPPER + 1,
  localparam int W        = LOW_W + UPPER_W * NUM_UPPER
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         count_en,
  output logic [W-1:0] count_value,
  output logic         terminal_count
);
  logic [NSEG-1:0] full;
  logic [NSEG-1:0] step;

  pc_enable_chain #(.NSEG(NSEG)) u_chain (
    .en   (count_en),
    .full (full),
    .step (step)
  );

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam int LSB = part_lsb(i, LOW_W, UPPER_W);
    localparam int SW  = part_width(i, LOW_W, UPPER_W);
    logic [SW-1:0] seg_val;

    pc_segment #(.SW(SW)) u_seg (
      .clk  (clk),
      .rst  (rst),
      .step (step[i]),
      .val  (seg_val),
      .full (full[i])
    );
    assign count_value[LSB +: SW] = seg_val;
  end

  assign terminal_count = &full;
endmodule

// File: rtl/prescaled_counter_chk.sv
module prescaled_counter_chk #(
  parameter int W     = 10,
  parameter int LOW_W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         count_en,
  input logic [W-1:0] count_value,
  input logic         terminal_count
);
  localparam logic [LOW_W-1:0] LOW_ONES = '1;
  localparam logic [W-1:0]     ALL_ONES = '1;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (count_value == '0 && !terminal_count));

  assert_enabled_increments_R2: assert property (@(posedge clk) disable iff (rst)
    count_en |=> count_value == W'($past(count_value) + 1'b1));

  assert_disabled_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !count_en |=> $stable(count_value));

  assert_upper_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (count_value[LOW_W-1:0] != LOW_ONES) |=> $stable(count_value[W-1:LOW_W]));

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (count_en && count_value == ALL_ONES) |=> count_value == '0);

  assert_tc_matches_R7: assert property (@(posedge clk) disable iff (rst)
    terminal_count == (count_value == ALL_ONES));
endmodule

bind prescaled_counter prescaled_counter_chk #(.W(W), .LOW_W(LOW_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .count_en       (count_en),
  .count_value    (count_value),
  .terminal_count (terminal_count)
);

// File: tb/prescaled_counter_test.sv
`timescale 1ns/1ps
module prescaled_counter_test;
  localparam int LOW_W = 4, UPPER_W = 3, NUM_UPPER = 2;
  localparam int W = LOW_W + UPPER_W * NUM_UPPER;
  localparam logic [W-1:0] ALL_ONES = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic count_en = 1'b0;
  logic [W-1:0] count_value;
  logic terminal_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_val = '0;

  always #5 clk = ~clk;

  prescaled_counter #(.LOW_W(LOW_W), .UPPER_W(UPPER_W), .NUM_UPPER(NUM_UPPER)) uut (
    .clk(clk), .rst(rst), .count_en(count_en),
    .count_value(count_value), .terminal_count(terminal_count)
  );

  function automatic logic [W-1:0] model_next(input logic [W-1:0] v, input logic r, input logic e);
    if (r) return '0;
    if (e) return v + 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Drive at negedge, let one posedge pass, compare at the next negedge.
  task automatic cycle(input logic r, input logic e);
    logic [W-1:0] prev;
    prev = exp_val;
    rst = r;
    count_en = e;
    @(posedge clk);
    exp_val = model_next(exp_val, r, e);
    @(negedge clk);
    check("R2/R3 full value", count_value, exp_val);
    check("R4 low partition", W'(count_value[LOW_W-1:0]), W'(exp_val[LOW_W-1:0]));
    check("R5 upper partitions", W'(count_value[W-1:LOW_W]), W'(exp_val[W-1:LOW_W]));
    check("R7 terminal count", W'(terminal_count), W'(exp_val == ALL_ONES));
    if (r) check("R1 reset", count_value, '0);
    if (!r && e && prev == ALL_ONES) check("R6 wrap", count_value, '0);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    @(negedge clk);
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1);   // R1 with enable high (R8-style override)
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0);   // R3 hold at zero
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1);  // R4/R5 directed low rollovers
    for (int i = 0; i < 4000; i++) cycle(1'b0, ($urandom_range(0, 3) != 0));
    cycle(1'b1, 1'b1);                               // R1 reset mid-run
    for (int i = 0; i < 1030; i++) cycle(1'b0, 1'b1); // R6 full-scale wrap
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0);   // R3 hold after wrap
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule